// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block keeps a four-bank single-data-rate SDRAM refreshed on behalf of a memory controller. A free-running interval counter, clocked by the system clock, marks each point at which one auto-refresh command falls due. It keeps a small count of refreshes that are owed, and signals the controller through `refresh_req`. When the controller hands over the command bus with `grant`, the block closes all rows with a precharge-all command. It waits the row-precharge time, issues one auto-refresh, and holds `busy` until the refresh cycle time has run out.

The block also puts the memory into self-refresh and brings it out again on host request. Entry follows the same precharge step and then issues the refresh encoding in the cycle where the clock-enable pin drops. Exit raises the clock-enable pin and keeps the bus for one clock plus a full refresh cycle time. The block drives the raw command pins and no data. All wait lengths come from picosecond parameters and the clock period. The wait lengths are rounded up. The refresh interval is rounded down.

Top module: `sdr_refresh_mgr`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes, the pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1, a10=0), cke=1, busy=0 and refresh_req=0.
- R2: Once every REFI_CYC clocks (REFI_PS / CLK_PERIOD_PS, rounded down) one refresh becomes owed. refresh_req is high whenever at least one refresh is owed, and it stays high while no sequence serves it.
- R3: The owed count saturates at MAX_PENDING. Each granted refresh sequence retires exactly one owed refresh, so postponed refreshes are caught up one sequence at a time.
- R4: A sequence opens with precharge-all: cs_n=0, ras_n=0, cas_n=1, we_n=0, a10=1, cke=1.
- R5: The next command follows precharge-all exactly TRP_CYC clocks later (ceil(TRP_PS/CLK_PERIOD_PS), at least 2), with NOP in between.
- R6: Auto-refresh is cs_n=0, ras_n=0, cas_n=0, we_n=1 with cke high in that cycle and in the cycle before it.
- R7: After auto-refresh, busy stays high and the pins stay NOP until TRC_CYC clocks (ceil(TRC_PS/CLK_PERIOD_PS), at least 2) have passed since the auto-refresh cycle. busy then falls.
- R8: A sequence starts only from the idle state and only while grant is high. Without grant the block drives NOP, keeps cke high and keeps busy low, even with a pending self-refresh entry request.
- R9: When grant and sr_enter_req are both high in idle, self-refresh entry wins over a pending refresh. The block issues precharge-all, waits TRP_CYC clocks, then drives the refresh encoding in the cycle where cke goes from 1 to 0. No auto-refresh with cke high is issued on this path.
- R10: While in self-refresh, cke stays 0, the owed count is cleared, and the interval counter is held at its reload value.
- R11: In self-refresh, sr_exit_req raises cke on the next clock. busy stays high with NOP for TRC_CYC+1 clocks counted from the first cycle with cke high. The interval counter then restarts from a full interval.
- R12: If an interval expires in the same cycle as an auto-refresh command, the owed count is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grant | input | 1 | Access engine hands the command bus to this block |
| sr_enter_req | input | 1 | Host asks to enter self-refresh |
| sr_exit_req | input | 1 | Host asks to leave self-refresh |
| cs_n | output | 1 | SDRAM chip select, active low |
| ras_n | output | 1 | Row address strobe, active low |
| cas_n | output | 1 | Column address strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10, selects all banks on precharge |
| cke | output | 1 | SDRAM clock enable |
| busy | output | 1 | Block owns the command bus (any state but idle) |
| refresh_req | output | 1 | At least one refresh is owed |

## Verification
Two functions can collide in one cycle: an interval expiring and the auto-refresh command that retires an owed refresh. The bench provokes this by sweeping the delay between a request appearing and the grant over a full interval. Every phase of the auto-refresh pulse is therefore placed against the expiry. A behavioural model of the owed count is compared with refresh_req on every clock, so a lost increment or a lost decrement shows up as a mismatch. The second overlap, a self-refresh entry request that arrives while a refresh is owed, is judged by checking that cke drops on the refresh encoding and that no auto-refresh with cke high is counted.

// File: rtl/sdr_refresh_pkg.sv
package sdr_refresh_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_PREALL = 3'd1,
    SQ_RPWAIT = 3'd2,
    SQ_AREF   = 3'd3,
    SQ_RCWAIT = 3'd4,
    SQ_SRENT  = 3'd5,
    SQ_SRHOLD = 3'd6,
    SQ_XSWAIT = 3'd7
  } seq_state_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic a10;
  } sdr_cmd_t;

  localparam sdr_cmd_t CMD_NOP    = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, a10: 1'b0};
  localparam sdr_cmd_t CMD_PREALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0, a10: 1'b1};
  localparam sdr_cmd_t CMD_AREF   = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1, a10: 1'b0};

  function automatic int cycles_up(input int span_ps, input int period_ps);
    int c;
    c = (span_ps + period_ps - 1) / period_ps;
    return (c < 2) ? 2 : c;
  endfunction

endpackage

// File: rtl/rfsh_interval_tmr.sv
module rfsh_interval_tmr #(
  parameter int REFI_CYC    = 1953,
  parameter int MAX_PENDING = 4,
  localparam int CW = (REFI_CYC > 1) ? $clog2(REFI_CYC) : 1,
  localparam int PW = $clog2(MAX_PENDING + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic served_i,
  output logic due_o
);

  localparam logic [CW-1:0] RELOAD = CW'(REFI_CYC - 1);
  localparam logic [PW-1:0] PMAX   = PW'(MAX_PENDING);

  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] pend_q, pend_d;
  logic          tick;
  logic          pend_en;

  assign tick = !hold_i && (cnt_q == '0);

  always_comb begin
    if (hold_i || tick) cnt_d = RELOAD;
    else                cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    pend_d = pend_q;
    if (hold_i)
      pend_d = '0;
    else if (tick && !served_i && (pend_q != PMAX))
      pend_d = pend_q + 1'b1;
    else if (served_i && !tick && (pend_q != '0))
      pend_d = pend_q - 1'b1;
  end

  assign pend_en = hold_i | tick | served_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RELOAD;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign due_o = (pend_q != '0);

endmodule

// File: rtl/rfsh_sequencer.sv
module rfsh_sequencer
  import sdr_refresh_pkg::*;
#(
  parameter int TRP_CYC = 3,
  parameter int TRC_CYC = 9,
  localparam int WMAX = (TRC_CYC > TRP_CYC) ? TRC_CYC : TRP_CYC,
  localparam int WW   = $clog2(WMAX + 1)
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     grant_i,
  input  logic     sr_enter_i,
  input  logic     sr_exit_i,
  input  logic     due_i,
  output sdr_cmd_t cmd_o,
  output logic     cke_o,
  output logic     busy_o,
  output logic     served_o,
  output logic     hold_o
);

  seq_state_t    state_q, state_d;
  logic [WW-1:0] wcnt_q, wcnt_d;
  logic          to_sr_q, to_sr_d;
  logic          to_sr_en;

  always_comb begin
    state_d  = state_q;
    wcnt_d   = wcnt_q;
    to_sr_d  = to_sr_q;
    to_sr_en = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (grant_i && (sr_enter_i || due_i)) begin
          state_d  = SQ_PREALL;
          to_sr_d  = sr_enter_i;
          to_sr_en = 1'b1;
        end
      end
      SQ_PREALL: begin
        state_d = SQ_RPWAIT;
        wcnt_d  = WW'(TRP_CYC - 2);
      end
      SQ_RPWAIT: begin
        if (wcnt_q == '0) state_d = to_sr_q ? SQ_SRENT : SQ_AREF;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      SQ_AREF: begin
        state_d = SQ_RCWAIT;
        wcnt_d  = WW'(TRC_CYC - 2);
      end
      SQ_RCWAIT: begin
        if (wcnt_q == '0) state_d = SQ_IDLE;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      SQ_SRENT:  state_d = SQ_SRHOLD;
      SQ_SRHOLD: begin
        if (sr_exit_i) begin
          state_d = SQ_XSWAIT;
          wcnt_d  = WW'(TRC_CYC);
        end
      end
      SQ_XSWAIT: begin
        if (wcnt_q == '0) state_d = SQ_IDLE;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        to_sr_q <= 1'b0;
    else if (to_sr_en) to_sr_q <= to_sr_d;
  end

  always_comb begin
    unique case (state_q)
      SQ_PREALL:         cmd_o = CMD_PREALL;
      SQ_AREF, SQ_SRENT: cmd_o = CMD_AREF;
      default:           cmd_o = CMD_NOP;
    endcase
  end

  assign hold_o   = (state_q == SQ_SRENT) || (state_q == SQ_SRHOLD);
  assign cke_o    = !hold_o;
  assign busy_o   = (state_q != SQ_IDLE);
  assign served_o = (state_q == SQ_AREF);

endmodule

// File: rtl/sdr_refresh_mgr.sv
module sdr_refresh_mgr
  import sdr_refresh_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 8000,
  parameter int REFI_PS       = 15_625_000,
  parameter int TRP_PS        = 20_000,
  parameter int TRC_PS        = 65_000,
  parameter int MAX_PENDING   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant,
  input  logic sr_enter_req,
  input  logic sr_exit_req,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic a10,
  output logic cke,
  output logic busy,
  output logic refresh_req
);

  localparam int REFI_CYC = (REFI_PS / CLK_PERIOD_PS < 2) ? 2 : REFI_PS / CLK_PERIOD_PS;
  localparam int TRP_CYC  = cycles_up(TRP_PS, CLK_PERIOD_PS);
  localparam int TRC_CYC  = cycles_up(TRC_PS, CLK_PERIOD_PS);

  logic     rs_q1, rs_q2;
  logic     due, served, hold;
  sdr_cmd_t cmd;

  // Reset asserts at once and is released two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end

  rfsh_interval_tmr #(
    .REFI_CYC    (REFI_CYC),
    .MAX_PENDING (MAX_PENDING)
  ) u_tmr (
    .clk      (clk),
    .rst_n    (rs_q2),
    .hold_i   (hold),
    .served_i (served),
    .due_o    (due)
  );

  rfsh_sequencer #(
    .TRP_CYC (TRP_CYC),
    .TRC_CYC (TRC_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rs_q2),
    .grant_i    (grant),
    .sr_enter_i (sr_enter_req),
    .sr_exit_i  (sr_exit_req),
    .due_i      (due),
    .cmd_o      (cmd),
    .cke_o      (cke),
    .busy_o     (busy),
    .served_o   (served),
    .hold_o     (hold)
  );

  assign cs_n        = cmd.cs_n;
  assign ras_n       = cmd.ras_n;
  assign cas_n       = cmd.cas_n;
  assign we_n        = cmd.we_n;
  assign a10         = cmd.a10;
  assign refresh_req = due;

endmodule

// File: rtl/sdr_refresh_mgr_chk.sv
module sdr_refresh_mgr_chk (
  input logic clk,
  input logic rst_n,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic a10,
  input logic cke,
  input logic busy,
  input logic refresh_req
);

  logic is_pre, is_ar, is_nop;
  assign is_pre = !cs_n && !ras_n && cas_n && !we_n && a10;
  assign is_ar  = !cs_n && !ras_n && !cas_n && we_n;
  assign is_nop = ras_n && cas_n && we_n;

  assert_pre_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |=> (is_nop && cke));

  assert_ar_cke_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ar && cke) |-> $past(cke));

  assert_req_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (refresh_req && !busy) |=> refresh_req);

  assert_cmd_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !is_nop |-> busy);

  assert_sr_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> is_ar);

  assert_sr_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> !refresh_req);

endmodule

bind sdr_refresh_mgr sdr_refresh_mgr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .ras_n       (ras_n),
  .cas_n       (cas_n),
  .we_n        (we_n),
  .a10         (a10),
  .cke         (cke),
  .busy        (busy),
  .refresh_req (refresh_req)
);

// File: tb/sdr_refresh_mgr_test.sv
module sdr_refresh_mgr_test;

  localparam int CLKPS    = 8000;
  localparam int MAXP     = 3;
  localparam int REFI_EXP = 60;
  localparam int TRP_EXP  = 3;
  localparam int TRC_EXP  = 9;

  logic clk = 1'b0;
  logic rst_n, grant, sr_enter_req, sr_exit_req;
  logic cs_n, ras_n, cas_n, we_n, a10, cke, busy, refresh_req;

  int checks = 0;
  int failures = 0;
  int wd_cyc = 0;
  int cyc = 0;
  int ar_count = 0;
  bit cmp_en = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdr_refresh_mgr #(
    .CLK_PERIOD_PS (CLKPS),
    .REFI_PS       (480_000),
    .TRP_PS        (20_000),
    .TRC_PS        (65_000),
    .MAX_PENDING   (MAXP)
  ) uut (
    .clk (clk), .rst_n (rst_n), .grant (grant),
    .sr_enter_req (sr_enter_req), .sr_exit_req (sr_exit_req),
    .cs_n (cs_n), .ras_n (ras_n), .cas_n (cas_n), .we_n (we_n),
    .a10 (a10), .cke (cke), .busy (busy), .refresh_req (refresh_req)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Behavioural model: phases 0 idle, 1 precharge, 2 row wait, 3 refresh,
  // 4 cycle wait, 5 entry, 6 inside self-refresh, 7 exit wait.
  int m_ph, m_w, m_cnt, m_pend, m_sr, m_r1, m_r2;
  bit m_td;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_ph = 0; m_w = 0;
      m_cnt = REFI_EXP - 1; m_pend = 0; m_sr = 0; m_td = 0;
    end else begin
      if (m_r2 != 0) begin
        bit hold, tick, dec;
        int nph, nw;
        hold = (m_ph == 5) || (m_ph == 6);
        tick = !hold && (m_cnt == 0);
        dec  = (m_ph == 3);
        m_td = tick && dec;
        nph = m_ph; nw = m_w;
        case (m_ph)
          0: if (grant && (sr_enter_req || m_pend > 0)) begin nph = 1; m_sr = sr_enter_req; end
          1: begin nph = 2; nw = TRP_EXP - 2; end
          2: if (m_w == 0) nph = (m_sr != 0) ? 5 : 3; else nw = m_w - 1;
          3: begin nph = 4; nw = TRC_EXP - 2; end
          4: if (m_w == 0) nph = 0; else nw = m_w - 1;
          5: nph = 6;
          6: if (sr_exit_req) begin nph = 7; nw = TRC_EXP; end
          default: if (m_w == 0) nph = 0; else nw = m_w - 1;
        endcase
        if (hold) m_pend = 0;
        else begin
          m_pend = m_pend + (tick ? 1 : 0) - (dec ? 1 : 0);
          if (m_pend > MAXP) m_pend = MAXP;
        end
        m_cnt = (hold || tick) ? REFI_EXP - 1 : m_cnt - 1;
        m_ph = nph; m_w = nw;
      end
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  function automatic string ph_tag(input int ph);
    case (ph)
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      5: return "R9";
      6: return "R10";
      7: return "R11";
      default: return "R8";
    endcase
  endfunction

  // Per-clock comparison plus timing monitor, all away from the rising edge.
  bit cke_prev = 1'b1, busy_prev = 1'b0, after_ar = 1'b0, after_xs = 1'b0;
  int last_pre = 0, last_ar = 0, last_rise = 0;

  always @(negedge clk) begin
    if (rst_n && cmp_en && !done) begin
      logic [4:0] e_cmd;
      bit is_pre, is_ar;
      cyc++;
      case (m_ph)
        1:       e_cmd = 5'b00101;
        3, 5:    e_cmd = 5'b00010;
        default: e_cmd = 5'b01110;
      endcase
      check({cs_n, ras_n, cas_n, we_n, a10} == e_cmd, ph_tag(m_ph), "command pins",
            int'({cs_n, ras_n, cas_n, we_n, a10}), int'(e_cmd));
      check(cke == !((m_ph == 5) || (m_ph == 6)), ph_tag(m_ph), "cke",
            int'(cke), int'(!((m_ph == 5) || (m_ph == 6))));
      check(busy == (m_ph != 0), "R7", "busy", int'(busy), int'(m_ph != 0));
      check(refresh_req == (m_pend > 0), m_td ? "R12" : "R2", "refresh_req",
            int'(refresh_req), int'(m_pend > 0));

      is_pre = !cs_n && !ras_n && cas_n && !we_n && a10;
      is_ar  = !cs_n && !ras_n && !cas_n && we_n;
      if (is_pre) last_pre = cyc;
      if (is_ar && cke) begin
        ar_count++;
        check(cyc - last_pre == TRP_EXP, "R5", "precharge to refresh gap", cyc - last_pre, TRP_EXP);
        check(cke_prev, "R6", "cke before refresh", int'(cke_prev), 1);
        last_ar = cyc; after_ar = 1'b1;
      end
      if (is_ar && !cke) begin
        check(cke_prev, "R9", "cke high before entry", int'(cke_prev), 1);
        check(cyc - last_pre == TRP_EXP, "R9", "precharge to entry gap", cyc - last_pre, TRP_EXP);
      end
      if (cke && !cke_prev) begin last_rise = cyc; after_xs = 1'b1; end
      if (busy_prev && !busy) begin
        if (after_ar) check(cyc - last_ar == TRC_EXP, "R7", "refresh to idle gap", cyc - last_ar, TRC_EXP);
        if (after_xs) check(cyc - last_rise == TRC_EXP + 1, "R11", "exit to idle gap", cyc - last_rise, TRC_EXP + 1);
        after_ar = 1'b0; after_xs = 1'b0;
      end
      cke_prev = cke; busy_prev = busy;
    end
  end

  always @(posedge clk) begin
    wd_cyc++;
    if (wd_cyc > 150000 && !done) begin
      checks++; failures++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", wd_cyc, 150000);
      finish_run();
    end
  end

  initial begin
    int ar_before;
    rst_n = 1'b0; grant = 1'b0; sr_enter_req = 1'b0; sr_exit_req = 1'b0;
    repeat (3) @(negedge clk);
    check({cs_n, ras_n, cas_n, we_n, a10} == 5'b01110, "R1", "reset pins", int'({cs_n, ras_n, cas_n, we_n, a10}), 14);
    check(cke && !busy && !refresh_req, "R1", "reset cke/busy/req", int'({cke, busy, refresh_req}), 4);
    rst_n = 1'b1; cmp_en = 1'b1;

    // Entry request without grant must do nothing.
    sr_enter_req = 1'b1;
    repeat (20) @(negedge clk);
    check(cke && !busy, "R8", "entry without grant", int'({cke, busy}), 2);
    sr_enter_req = 1'b0;

    // Let owed refreshes pile up past the saturation point.
    repeat (400) @(negedge clk);
    check(refresh_req, "R2", "request after intervals", int'(refresh_req), 1);

    // Catch up with the bus granted continuously.
    ar_count = 0; grant = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (!refresh_req && !busy) break;
    end
    grant = 1'b0;
    check(ar_count >= MAXP, "R3", "catch-up refresh count", ar_count, MAXP);
    check(!refresh_req, "R3", "request cleared after catch-up", int'(refresh_req), 0);

    // Sweep grant delay so a refresh lands on an interval expiry.
    for (int d = 0; d < REFI_EXP; d++) begin
      while (!refresh_req) @(negedge clk);
      repeat (d) @(negedge clk);
      grant = 1'b1;
      @(negedge clk);
      while (!busy) @(negedge clk);
      grant = 1'b0;
      while (busy) @(negedge clk);
    end

    // Self-refresh entry with a refresh owed.
    while (!refresh_req) @(negedge clk);
    ar_before = ar_count;
    grant = 1'b1; sr_enter_req = 1'b1;
    while (cke) @(negedge clk);
    grant = 1'b0; sr_enter_req = 1'b0;
    check(ar_count == ar_before, "R9", "no refresh with cke high on entry path", ar_count, ar_before);
    repeat (200) @(negedge clk);
    check(!cke && !refresh_req, "R10", "held in self-refresh", int'({cke, refresh_req}), 0);

    sr_exit_req = 1'b1;
    @(negedge clk);
    sr_exit_req = 1'b0;
    check(cke, "R11", "cke raised on exit", int'(cke), 1);
    while (busy) @(negedge clk);
    repeat (REFI_EXP + 5) @(negedge clk);
    check(refresh_req, "R11", "interval restarts after exit", int'(refresh_req), 1);

    finish_run();
  end

endmodule